// File: doc/BRIEF.md
# Separable Restoration Filter Coefficient Projection Stage

This block carries out one half of the alternating coefficient refinement for a 7-tap separable restoration filter whose taps are symmetric. While one direction's tap vector is held constant on an input, the block walks every tap pair (i, j) with i in the outer loop and j in the inner loop. For each pair it takes one pre-folded 4x4 autocovariance tile and projects it through the quadratic form t(i)·t(j). For the beats where j equals 0, it also takes one pre-folded 4-element cross-correlation row weighted by t(i). The result is a 4x4 coefficient matrix and a 4-element constant vector.

The taps must sum to the fixed value 65536. The centre tap therefore follows from the other three. An enforcement stage uses this to fold the 4-unknown system into a 3-unknown system, which goes to an external solver. A separate combinational path accepts the solver's three outer taps and rebuilds the full mirrored 7-tap filter, including its implied centre.

Statistics come in over a valid/ready stream. The block reports the (i, j) pair that it expects next, so the source can address its tile memory.

Top module: `wiener_proj`

## Requirements
- R1: After reset, busy, done and tile_ready are 0, and both reduced outputs read zero.
- R2: A start pulse while idle clears both accumulators, sets busy, and raises tile_ready, which stays high until the 49th tile has been accepted.
- R3: Tiles are consumed in the order j = 0..6 inside i = 0..6. cur_i and cur_j show the pair of the next tile and advance only on a cycle where tile_valid and tile_ready are both 1.
- R4: Every accepted tile adds to matrix element k (row k/4, column k%4, held at bits [32k+31:32k] of tile_h) the value ((H·t(i)) >>> 16 · t(j)) >>> 16. The arithmetic is signed and the result is truncated to 64 bits. Tap n occupies bits [32n+31:32n] of taps_in.
- R5: The vector accumulator adds (M_k·t(i)) >>> 16 only for beats with j = 0. tile_m on beats with j ≠ 0 has no effect.
- R6: For k, l in 0..2 (output index 3k+l), the reduced matrix is B[k][l] − 2B[k][3] − 2B[3][l] + 4B[3][3]. The reduced vector is A[k] − 2A[3] − 65536·(B[k][3] − 2B[3][3]), also truncated to 64 bits.
- R7: done is high for exactly one cycle, after all 49 tiles have drained through the multiplier pipeline. busy falls in that same cycle. The reduced outputs update only together with done.
- R8: A start pulse while busy is ignored, and the ongoing accumulation completes unchanged.
- R9: The rebuild path outputs taps 0..2 as sol 0..2, tap 6−n equal to tap n, and centre tap 65536 − 2·(sol0+sol1+sol2), modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a projection pass |
| taps_in | input | 224 | Held tap vector, 7 signed Q16 values |
| tile_valid | input | 1 | Tile beat present |
| tile_ready | output | 1 | Block accepts a beat |
| tile_h | input | 512 | Folded 4x4 autocovariance tile, 16 signed 32-bit |
| tile_m | input | 128 | Folded cross-correlation row, 4 signed 32-bit |
| cur_i | output | 3 | Outer pair index of next beat |
| cur_j | output | 3 | Inner pair index of next beat |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| red_b | output | 576 | Reduced 3x3 matrix, 9 signed 64-bit |
| red_a | output | 192 | Reduced 3-vector, 3 signed 64-bit |
| sol_in | input | 96 | Three solved outer taps |
| taps_out | output | 224 | Rebuilt 7-tap symmetric filter |

## Verification
The bench inserts idle gaps in the tile stream. A design that advanced its indices without a handshake would skip or repeat tiles, which would show up both as wrong reported pairs and as wrong sums. It drives junk cross-correlation data on beats with j ≠ 0, which catches a vector accumulator that fails to gate on j. It uses negative taps and negative statistics, where a logical shift in place of an arithmetic one gives large wrong values. It pulses start in the middle of a pass, where a design that restarts would lose the earlier tiles. It also checks the centre-tap rebuild with sums that exceed the fixed total.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int NTAP  = 7;
    localparam int NFOLD = 4;
    localparam int NRED  = 3;
    localparam int DW    = 32;
    localparam int AW    = 64;
    localparam int FRAC  = 16;
    localparam int SUM_LOG2 = 16;
    localparam int NB    = NFOLD * NFOLD;
    localparam int NRB   = NRED * NRED;
    localparam int IW    = $clog2(NTAP);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FOLD  = 2'd3
    } wp_state_e;
endpackage

// File: rtl/wp_lane.sv
module wp_lane #(
    parameter int DW        = 32,
    parameter int AW        = 64,
    parameter int FRAC      = 16,
    parameter bit TWO_STAGE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] ti_i,
    input  logic [DW-1:0] tj_i,
    output logic          vld_o,
    output logic          busy_o,
    output logic [AW-1:0] p_o
);
    localparam int PW = AW + DW;

    typedef struct packed {
        logic          v1;
        logic [AW-1:0] p1;
        logic [DW-1:0] tj;
        logic          v2;
        logic [AW-1:0] p2;
    } lane_t;

    lane_t d, q;
    logic signed [AW-1:0] m1;
    logic [AW-1:0]        p2_val;

    generate
        if (TWO_STAGE) begin : g_two
            logic signed [PW-1:0] m2;
            always_comb begin
                m2     = PW'($signed(q.p1)) * PW'($signed(q.tj));
                p2_val = m2[AW+FRAC-1:FRAC];
            end
        end else begin : g_one
            always_comb p2_val = q.p1;
        end
    endgenerate

    always_comb begin
        d    = q;
        m1   = AW'($signed(x_i)) * AW'($signed(ti_i));
        d.v1 = vld_i;
        d.p1 = m1 >>> FRAC;
        d.tj = tj_i;
        d.v2 = q.v1;
        d.p2 = p2_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld_o  = q.v2;
    assign busy_o = q.v1 | q.v2;
    assign p_o    = q.p2;

    AST_LANE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> ##1 vld_o); // R4
endmodule

// File: rtl/wp_fold.sv
module wp_fold
    import wp_pkg::*;
(
    input  logic [NB*AW-1:0]    acc_b_i,
    input  logic [NFOLD*AW-1:0] acc_a_i,
    output logic [NRB*AW-1:0]   red_b_o,
    output logic [NRED*AW-1:0]  red_a_o
);
    function automatic logic signed [AW-1:0] bel(input int r, input int c);
        return $signed(acc_b_i[(r*NFOLD+c)*AW +: AW]);
    endfunction

    always_comb begin
        for (int k = 0; k < NRED; k++) begin
            for (int l = 0; l < NRED; l++) begin
                red_b_o[(k*NRED+l)*AW +: AW] = bel(k, l) - 2*bel(k, NRED)
                    - 2*bel(NRED, l) + 4*bel(NRED, NRED);
            end
            red_a_o[k*AW +: AW] = $signed(acc_a_i[k*AW +: AW])
                - 2*$signed(acc_a_i[NRED*AW +: AW])
                - ((bel(k, NRED) - 2*bel(NRED, NRED)) <<< SUM_LOG2);
        end
    end
endmodule

// File: rtl/wp_rebuild.sv
module wp_rebuild
    import wp_pkg::*;
(
    input  logic [NRED*DW-1:0] sol_i,
    output logic [NTAP*DW-1:0] taps_o
);
    logic [DW-1:0] outer_sum;

    always_comb begin
        outer_sum = '0;
        for (int n = 0; n < NRED; n++) begin
            taps_o[n*DW +: DW]          = sol_i[n*DW +: DW];
            taps_o[(NTAP-1-n)*DW +: DW] = sol_i[n*DW +: DW];
            outer_sum = outer_sum + sol_i[n*DW +: DW];
        end
        taps_o[NRED*DW +: DW] = (DW'(1) << SUM_LOG2) - (outer_sum << 1);
    end
endmodule

// File: rtl/wiener_proj.sv
module wiener_proj
    import wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NTAP*DW-1:0]  taps_in,
    input  logic                tile_valid,
    output logic                tile_ready,
    input  logic [NB*DW-1:0]    tile_h,
    input  logic [NFOLD*DW-1:0] tile_m,
    output logic [IW-1:0]       cur_i,
    output logic [IW-1:0]       cur_j,
    output logic                busy,
    output logic                done,
    output logic [NRB*AW-1:0]   red_b,
    output logic [NRED*AW-1:0]  red_a,
    input  logic [NRED*DW-1:0]  sol_in,
    output logic [NTAP*DW-1:0]  taps_out
);
    localparam logic [IW-1:0] LAST = IW'(NTAP - 1);

    typedef struct packed {
        wp_state_e               st;
        logic [IW-1:0]           ci;
        logic [IW-1:0]           cj;
        logic [NB-1:0][AW-1:0]   acc_b;
        logic [NFOLD-1:0][AW-1:0] acc_a;
        logic [NRB*AW-1:0]       red_b;
        logic [NRED*AW-1:0]      red_a;
        logic                    done;
    } top_t;

    top_t d, q;
    logic hs;
    logic [DW-1:0] t_i, t_j;
    logic [NB-1:0]          vb, bb;
    logic [NB-1:0][AW-1:0]  pb;
    logic [NFOLD-1:0]       va, ba;
    logic [NFOLD-1:0][AW-1:0] pa;
    logic [NRB*AW-1:0]  fold_b;
    logic [NRED*AW-1:0] fold_a;

    assign tile_ready = (q.st == ST_RUN);
    assign hs  = tile_valid && tile_ready;
    assign t_i = taps_in[q.ci*DW +: DW];
    assign t_j = taps_in[q.cj*DW +: DW];

    generate
        for (genvar k = 0; k < NB; k++) begin : g_blane
            wp_lane #(.DW(DW), .AW(AW), .FRAC(FRAC), .TWO_STAGE(1'b1)) u_lane (
                .clk(clk), .rst_n(rst_n), .vld_i(hs),
                .x_i(tile_h[k*DW +: DW]), .ti_i(t_i), .tj_i(t_j),
                .vld_o(vb[k]), .busy_o(bb[k]), .p_o(pb[k]));
        end
        for (genvar k = 0; k < NFOLD; k++) begin : g_alane
            wp_lane #(.DW(DW), .AW(AW), .FRAC(FRAC), .TWO_STAGE(1'b0)) u_lane (
                .clk(clk), .rst_n(rst_n), .vld_i(hs && (q.cj == '0)),
                .x_i(tile_m[k*DW +: DW]), .ti_i(t_i), .tj_i(t_j),
                .vld_o(va[k]), .busy_o(ba[k]), .p_o(pa[k]));
        end
    endgenerate

    wp_fold u_fold (.acc_b_i(q.acc_b), .acc_a_i(q.acc_a),
                    .red_b_o(fold_b), .red_a_o(fold_a));

    wp_rebuild u_rebuild (.sol_i(sol_in), .taps_o(taps_out));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        for (int k = 0; k < NB; k++)
            if (vb[k]) d.acc_b[k] = q.acc_b[k] + pb[k];
        for (int k = 0; k < NFOLD; k++)
            if (va[k]) d.acc_a[k] = q.acc_a[k] + pa[k];
        unique case (q.st)
            ST_IDLE: if (start) begin
                d.st    = ST_RUN;
                d.ci    = '0;
                d.cj    = '0;
                d.acc_b = '0;
                d.acc_a = '0;
            end
            ST_RUN: if (hs) begin
                if (q.cj == LAST) begin
                    d.cj = '0;
                    if (q.ci == LAST) begin
                        d.ci = '0;
                        d.st = ST_DRAIN;
                    end else begin
                        d.ci = q.ci + 1'b1;
                    end
                end else begin
                    d.cj = q.cj + 1'b1;
                end
            end
            ST_DRAIN: if (!(|bb) && !(|ba)) d.st = ST_FOLD;
            ST_FOLD: begin
                d.red_b = fold_b;
                d.red_a = fold_a;
                d.done  = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_i = q.ci;
    assign cur_j = q.cj;
    assign busy  = (q.st != ST_IDLE);
    assign done  = q.done;
    assign red_b = q.red_b;
    assign red_a = q.red_a;

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tile_ready |-> busy); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_i <= LAST) && (cur_j <= LAST)); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_ready && !tile_valid) |=> ($stable(cur_i) && $stable(cur_j))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(red_a) && $stable(red_b)))); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start && !(q.st == ST_FOLD)) |=> busy); // R8
endmodule

// File: tb/wiener_proj_bench.sv
module wiener_proj_bench;
    import wp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NTAP*DW-1:0]  taps_in = '0;
    logic tile_valid = 1'b0;
    logic tile_ready;
    logic [NB*DW-1:0]    tile_h = '0;
    logic [NFOLD*DW-1:0] tile_m = '0;
    logic [IW-1:0] cur_i, cur_j;
    logic busy, done;
    logic [NRB*AW-1:0]  red_b;
    logic [NRED*AW-1:0] red_a;
    logic [NRED*DW-1:0] sol_in = '0;
    logic [NTAP*DW-1:0] taps_out;

    int total = 0;
    int bad = 0;

    int     h [7][7][16];
    int     m [7][4];
    int     tv[7];
    longint eb[16];
    longint ea[4];

    always #2.5 clk = ~clk;

    wiener_proj u_wiener_proj (
        .clk(clk), .rst_n(rst_n), .start(start), .taps_in(taps_in),
        .tile_valid(tile_valid), .tile_ready(tile_ready), .tile_h(tile_h),
        .tile_m(tile_m), .cur_i(cur_i), .cur_j(cur_j), .busy(busy), .done(done),
        .red_b(red_b), .red_a(red_a), .sol_in(sol_in), .taps_out(taps_out));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int mag);
        return int'($urandom_range(2*mag, 0)) - mag;
    endfunction

    task automatic fill(input int hmag, input int tmag, input bit neg_only);
        for (int i = 0; i < 7; i++) begin
            tv[i] = neg_only ? -int'($urandom_range(tmag, 1)) : rnd(tmag);
            for (int k = 0; k < 4; k++) m[i][k] = neg_only ? -int'($urandom_range(hmag, 1)) : rnd(hmag);
            for (int j = 0; j < 7; j++)
                for (int k = 0; k < 16; k++)
                    h[i][j][k] = neg_only ? -int'($urandom_range(hmag, 1)) : rnd(hmag);
        end
    endtask

    task automatic model();
        longint p1, p2;
        for (int k = 0; k < 16; k++) eb[k] = 0;
        for (int k = 0; k < 4; k++) ea[k] = 0;
        for (int i = 0; i < 7; i++) begin
            for (int k = 0; k < 4; k++) ea[k] += (longint'(m[i][k]) * longint'(tv[i])) >>> 16;
            for (int j = 0; j < 7; j++)
                for (int k = 0; k < 16; k++) begin
                    p1 = (longint'(h[i][j][k]) * longint'(tv[i])) >>> 16;
                    p2 = (p1 * longint'(tv[j])) >>> 16;
                    eb[k] += p2;
                end
        end
    endtask

    task automatic check_reduced(input string tag);
        longint eb_red, ea_red, got;
        for (int k = 0; k < 3; k++) begin
            for (int l = 0; l < 3; l++) begin
                eb_red = eb[k*4+l] - 2*eb[k*4+3] - 2*eb[12+l] + 4*eb[15];
                got = longint'(red_b[(k*3+l)*AW +: AW]);
                chk(got == eb_red, {tag, " R4 R6 matrix"}, got, eb_red);
            end
            ea_red = ea[k] - 2*ea[3] - (eb[k*4+3] - 2*eb[15]) * 65536;
            got = longint'(red_a[k*AW +: AW]);
            chk(got == ea_red, {tag, " R5 R6 vector"}, got, ea_red);
        end
    endtask

    // Feeds all 49 tiles; gaps inserts idle cycles; mid_start pulses start mid-pass.
    task automatic run_pass(input string tag, input bit gaps, input bit mid_start);
        bit acc;
        int waitc;
        for (int n = 0; n < 7; n++) taps_in[n*DW +: DW] = tv[n];
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && tile_ready, {tag, " R2 busy/ready after start"}, {busy, tile_ready}, 2'b11);
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                if (gaps && ((i + j) % 3 == 0)) begin
                    tile_valid = 1'b0;
                    tile_h = '1;
                    @(negedge clk);
                end
                for (int k = 0; k < 16; k++) tile_h[k*DW +: DW] = h[i][j][k];
                for (int k = 0; k < 4; k++)
                    tile_m[k*DW +: DW] = (j == 0) ? m[i][k] : 32'h7fff_0000 + k;
                tile_valid = 1'b1;
                if (mid_start && i == 3 && j == 2) start = 1'b1;
                acc = 1'b0;
                while (!acc) begin
                    if (tile_ready) begin
                        chk(cur_i == 3'(i) && cur_j == 3'(j), {tag, " R3 pair order"},
                            {cur_i, cur_j}, {3'(i), 3'(j)});
                        acc = 1'b1;
                    end
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        end
        tile_valid = 1'b0;
        chk(!tile_ready, {tag, " R2 ready drops after last tile"}, tile_ready, 0);
        waitc = 0;
        while (!done && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        chk(done && !busy, {tag, " R7 done with busy low"}, {done, busy}, 2'b10);
        model();
        check_reduced(tag);
        @(negedge clk);
        chk(!done, {tag, " R7 done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !tile_ready, "R1 control idle", {busy, done, tile_ready}, 0);
        chk(red_b == '0 && red_a == '0, "R1 outputs zero", 0, 0);
    endtask

    task automatic t_hold();
        logic [NRB*AW-1:0] sb;
        logic [NRED*AW-1:0] sa;
        sb = red_b;
        sa = red_a;
        for (int n = 0; n < 5; n++) @(negedge clk);
        chk(red_b == sb && red_a == sa && !done, "R7 outputs held while idle", 0, 0);
    endtask

    task automatic t_rebuild(input int s0, input int s1, input int s2);
        int exp_c, got;
        sol_in = {s2, s1, s0};
        #1;
        exp_c = 65536 - 2*(s0 + s1 + s2);
        got = int'(taps_out[3*DW +: DW]);
        chk(got == exp_c, "R9 centre tap", got, exp_c);
        chk(taps_out[0 +: DW] == s0 && taps_out[6*DW +: DW] == s0, "R9 tap0 mirror", int'(taps_out[6*DW +: DW]), s0);
        chk(taps_out[DW +: DW] == s1 && taps_out[5*DW +: DW] == s1, "R9 tap1 mirror", int'(taps_out[5*DW +: DW]), s1);
        chk(taps_out[2*DW +: DW] == s2 && taps_out[4*DW +: DW] == s2, "R9 tap2 mirror", int'(taps_out[4*DW +: DW]), s2);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fill(1 << 20, 1 << 17, 1'b0);
        run_pass("plain", 1'b0, 1'b0);
        t_hold();
        fill(1 << 20, 1 << 17, 1'b1);
        run_pass("negative", 1'b1, 1'b0);
        fill(1 << 12, 1 << 16, 1'b0);
        tv[3] = 65536;
        run_pass("mid-start R8", 1'b1, 1'b1);
        t_rebuild(1000, -2000, 3000);
        t_rebuild(20000, 15000, 10000);
        t_rebuild(-5, 0, 7);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule